// File: doc/BRIEF.md
# Multilevel Cell Write-Verify Controller

This block programs a single multilevel storage cell to one of four resistance levels. On a start request it drives a programming-current code to an external pulse generator and waits for that generator to acknowledge the pulse. For the two middle levels it then asks the readout converter for an 8-bit read-current value. It compares that value with a programmable target and a half-window, and repeats the pulse-then-read cycle until the cell lands inside the window or an iteration budget runs out.

The two outer levels need no verification. The lowest level is written with one full-strength reset pulse and the highest with one set pulse, and the operation finishes right after the acknowledge. The middle levels start from a preset current code chosen for each level. After every out-of-window read, the code is corrected in proportion to the signed read error. This follows the programming curve of each individual cell instead of stepping by a fixed amount. A larger current makes the cell more resistive and so lowers the read current, so a read that is too high raises the code and a read that is too low lowers it.

When the operation finishes, the block pulses a done flag. Along with it, it reports whether the cell missed its window and how many pulses were spent.

Top module: `mlcWriteVerify`

## Requirements
- R1: After reset, `done`, `fail`, `pulseReq` and `readReq` are 0 and `iterCount` is 0.
- R2: Level code 0 issues exactly one pulse with code RESET_CODE (default 255), and level code 3 issues exactly one pulse with code SET_CODE (default 32). Neither issues a read request, and both finish with `fail`=0 and `iterCount`=1.
- R3: The first pulse for level code 1 uses GUESS_L1 (default 150), and the first pulse for level code 2 uses GUESS_L2 (default 110).
- R4: For level codes 1 and 2, every acknowledged pulse is followed by exactly one read. The operation passes (`fail`=0) as soon as |read - target| <= margin, where level 1 uses `cfgTarget1`/`cfgMargin1` and level 2 uses `cfgTarget2`/`cfgMargin2`.
- R5: After an out-of-window read, the next pulse code is code + ((read - target) >>> GAIN_SHIFT), using an arithmetic shift with GAIN_SHIFT defaulting to 1.
- R6: An out-of-window read always moves the code by at least one LSB in the direction of the error sign, even when the shifted error is 0.
- R7: The corrected code saturates to the range 0 to 255.
- R8: If the read is still outside the window when `iterCount` reaches `cfgMaxIter`, the operation ends with `fail`=1. A `cfgMaxIter` of 0 acts as 1. A read that lands inside the window on the last allowed pulse passes.
- R9: `pulseReq` stays high with a stable `pulseCode` until `pulseAck`. `readReq` stays high until `readValid`, and `readData` is taken in that cycle. An acknowledge may arrive in the first cycle of a request.
- R10: `start` and `levelIn` are ignored while an operation is in progress.
- R11: `done` is high for exactly one cycle per operation. `fail` and `iterCount` hold their final values until the next accepted start.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| levelIn | input | 2 | Target level code 0..3 |
| cfgTarget1 | input | 8 | Read target for level 1 |
| cfgMargin1 | input | 8 | Acceptance half-window for level 1 |
| cfgTarget2 | input | 8 | Read target for level 2 |
| cfgMargin2 | input | 8 | Acceptance half-window for level 2 |
| cfgMaxIter | input | 5 | Pulse budget per operation |
| pulseReq | output | 1 | Pulse request to the generator |
| pulseCode | output | 8 | Programming-current code |
| pulseAck | input | 1 | Pulse completed |
| readReq | output | 1 | Read request to the converter |
| readValid | input | 1 | Read result valid |
| readData | input | 8 | Digitized read current |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | Cell missed its window within budget |
| iterCount | output | 5 | Pulses issued in the last operation |

## Verification
Two decisions of this block can fall in the same evaluation cycle: the window hit and the exhausted pulse budget. The bench first measures how many pulses a given cell response needs in order to converge. It then repeats the operation with `cfgMaxIter` set to exactly that count, which forces both conditions to be true together. It judges the outcome as a pass with that iteration count. A second overlap comes from acknowledges that arrive in the same cycle that a request rises. The bench provokes this with zero-latency responders, and it judges it by checking that the pulse sequence and the read count match the model.

// File: rtl/mlcWvPkg.sv
package mlcWvPkg;

  localparam int LEVEL_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT_PULSE,
    ST_READ,
    ST_WAIT_READ,
    ST_EVAL,
    ST_FINISH
  } wvState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic incIter;
    logic capRead;
    logic stepCode;
    logic setResult;
    logic resultFail;
  } wvStrobe_t;

  function automatic logic isOuterLevel(input logic [LEVEL_W-1:0] lvl);
    return (lvl == '0) || (lvl == '1);
  endfunction

endpackage

// File: rtl/mlcWvDatapath.sv
module mlcWvDatapath
  import mlcWvPkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int ADC_W      = 8,
  parameter int ITER_W     = 5,
  parameter int GAIN_SHIFT = 1,
  parameter int RESET_CODE = 255,
  parameter int SET_CODE   = 32,
  parameter int GUESS_L1   = 150,
  parameter int GUESS_L2   = 110
) (
  input  logic               clk,
  input  logic               rstN,
  input  wvStrobe_t          stb,
  input  logic [LEVEL_W-1:0] levelIn,
  input  logic [ADC_W-1:0]   readData,
  input  logic [ADC_W-1:0]   cfgTarget1,
  input  logic [ADC_W-1:0]   cfgMargin1,
  input  logic [ADC_W-1:0]   cfgTarget2,
  input  logic [ADC_W-1:0]   cfgMargin2,
  input  logic [ITER_W-1:0]  cfgMaxIter,
  output logic [CODE_W-1:0]  pulseCode,
  output logic [ITER_W-1:0]  iterCount,
  output logic               fail,
  output logic               endLevel,
  output logic               inWindow,
  output logic               iterLimit
);

  localparam int ERR_W   = ADC_W + 1;
  localparam int SUM_W   = ((CODE_W > ERR_W) ? CODE_W : ERR_W) + 2;
  localparam int NUM_MID = 2;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic signed [SUM_W-1:0] CODE_MAX_S = SUM_W'({1'b0, CODE_MAX});

  logic [LEVEL_W-1:0] levelQ;
  logic [ADC_W-1:0]   readQ;
  logic [CODE_W-1:0]  codeQ;
  logic [CODE_W-1:0]  initCode;
  logic [CODE_W-1:0]  nextCode;
  logic [ITER_W-1:0]  iterQ;
  logic               failQ;

  // per middle level target / window
  logic [ADC_W-1:0]        tgtArr [NUM_MID];
  logic [ADC_W-1:0]        mgArr  [NUM_MID];
  logic signed [ERR_W-1:0] errArr [NUM_MID];
  logic [NUM_MID-1:0]      winVec;

  assign tgtArr[0] = cfgTarget1;
  assign tgtArr[1] = cfgTarget2;
  assign mgArr[0]  = cfgMargin1;
  assign mgArr[1]  = cfgMargin2;

  generate
    for (genvar g = 0; g < NUM_MID; g++) begin : gMid
      logic [ERR_W-1:0] absErr;
      assign errArr[g] = $signed({1'b0, readQ}) - $signed({1'b0, tgtArr[g]});
      assign absErr    = errArr[g][ERR_W-1] ? $unsigned(-errArr[g]) : $unsigned(errArr[g]);
      assign winVec[g] = (absErr <= {1'b0, mgArr[g]});
    end
  endgenerate

  logic                    midSel;
  logic signed [ERR_W-1:0] errSel;
  logic signed [ERR_W-1:0] stepRaw;
  logic signed [ERR_W-1:0] stepEff;
  logic signed [SUM_W-1:0] sumCode;

  assign midSel   = (levelQ == LEVEL_W'(2));
  assign errSel   = errArr[midSel];
  assign inWindow = winVec[midSel];
  assign endLevel = isOuterLevel(levelQ);

  always_comb begin
    stepRaw = errSel >>> GAIN_SHIFT;
    if (stepRaw == '0) begin
      stepEff = errSel[ERR_W-1] ? {ERR_W{1'b1}} : ERR_W'(1);
    end else begin
      stepEff = stepRaw;
    end
    sumCode = $signed({{(SUM_W-CODE_W){1'b0}}, codeQ})
            + $signed({{(SUM_W-ERR_W){stepEff[ERR_W-1]}}, stepEff});
    if (sumCode[SUM_W-1]) begin
      nextCode = '0;
    end else if (sumCode > CODE_MAX_S) begin
      nextCode = CODE_MAX;
    end else begin
      nextCode = sumCode[CODE_W-1:0];
    end
  end

  always_comb begin
    unique case (levelIn)
      2'd0:    initCode = CODE_W'(RESET_CODE);
      2'd1:    initCode = CODE_W'(GUESS_L1);
      2'd2:    initCode = CODE_W'(GUESS_L2);
      default: initCode = CODE_W'(SET_CODE);
    endcase
  end

  assign iterLimit = (cfgMaxIter == '0) ? (iterQ != '0) : (iterQ >= cfgMaxIter);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      readQ  <= '0;
      codeQ  <= '0;
      iterQ  <= '0;
      failQ  <= 1'b0;
    end else begin
      if (stb.load) begin
        levelQ <= levelIn;
        codeQ  <= initCode;
        readQ  <= '0;
        iterQ  <= '0;
        failQ  <= 1'b0;
      end
      if (stb.incIter)   iterQ <= ITER_W'(iterQ + 1'b1);
      if (stb.capRead)   readQ <= readData;
      if (stb.stepCode)  codeQ <= nextCode;
      if (stb.setResult) failQ <= stb.resultFail;
    end
  end

  assign pulseCode = codeQ;
  assign iterCount = iterQ;
  assign fail      = failQ;

  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> iterLimit && !inWindow); // R8

  AST_MIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepCode && !inWindow |=> (pulseCode != $past(pulseCode)) || (pulseCode == '0) || (pulseCode == CODE_MAX)); // R6

  AST_PASS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.setResult && !stb.resultFail && !endLevel |-> inWindow); // R4

endmodule

// File: rtl/mlcWvControl.sv
module mlcWvControl
  import mlcWvPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      pulseAck,
  input  logic      readValid,
  input  logic      endLevel,
  input  logic      inWindow,
  input  logic      iterLimit,
  output wvStrobe_t stb,
  output logic      pulseReq,
  output logic      readReq,
  output logic      done
);

  wvState_e state;
  wvState_e nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.load  = 1'b1;
          nextState = ST_PULSE;
        end
      end
      ST_PULSE, ST_WAIT_PULSE: begin
        stb.incIter = (state == ST_PULSE);
        if (pulseAck) begin
          if (endLevel) begin
            stb.setResult = 1'b1;
            nextState     = ST_FINISH;
          end else begin
            nextState = ST_READ;
          end
        end else begin
          nextState = ST_WAIT_PULSE;
        end
      end
      ST_READ, ST_WAIT_READ: begin
        if (readValid) begin
          stb.capRead = 1'b1;
          nextState   = ST_EVAL;
        end else begin
          nextState = ST_WAIT_READ;
        end
      end
      ST_EVAL: begin
        if (inWindow) begin
          stb.setResult = 1'b1;
          nextState     = ST_FINISH;
        end else if (iterLimit) begin
          stb.setResult  = 1'b1;
          stb.resultFail = 1'b1;
          nextState      = ST_FINISH;
        end else begin
          stb.stepCode = 1'b1;
          nextState    = ST_PULSE;
        end
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign pulseReq = (state == ST_PULSE) || (state == ST_WAIT_PULSE);
  assign readReq  = (state == ST_READ)  || (state == ST_WAIT_READ);
  assign done     = (state == ST_FINISH);

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pulseReq && !pulseAck |=> pulseReq); // R9

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    readReq && !readValid |=> readReq); // R9

  AST_OUTER_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    readReq |-> !endLevel); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

endmodule

// File: rtl/mlcWriteVerify.sv
module mlcWriteVerify
  import mlcWvPkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int ADC_W      = 8,
  parameter int ITER_W     = 5,
  parameter int GAIN_SHIFT = 1,
  parameter int RESET_CODE = 255,
  parameter int SET_CODE   = 32,
  parameter int GUESS_L1   = 150,
  parameter int GUESS_L2   = 110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        levelIn,
  input  logic [ADC_W-1:0]  cfgTarget1,
  input  logic [ADC_W-1:0]  cfgMargin1,
  input  logic [ADC_W-1:0]  cfgTarget2,
  input  logic [ADC_W-1:0]  cfgMargin2,
  input  logic [ITER_W-1:0] cfgMaxIter,
  output logic              pulseReq,
  output logic [CODE_W-1:0] pulseCode,
  input  logic              pulseAck,
  output logic              readReq,
  input  logic              readValid,
  input  logic [ADC_W-1:0]  readData,
  output logic              done,
  output logic              fail,
  output logic [ITER_W-1:0] iterCount
);

  wvStrobe_t stb;
  logic      endLevel;
  logic      inWindow;
  logic      iterLimit;

  mlcWvControl i_control (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .pulseAck  (pulseAck),
    .readValid (readValid),
    .endLevel  (endLevel),
    .inWindow  (inWindow),
    .iterLimit (iterLimit),
    .stb       (stb),
    .pulseReq  (pulseReq),
    .readReq   (readReq),
    .done      (done)
  );

  mlcWvDatapath #(
    .CODE_W     (CODE_W),
    .ADC_W      (ADC_W),
    .ITER_W     (ITER_W),
    .GAIN_SHIFT (GAIN_SHIFT),
    .RESET_CODE (RESET_CODE),
    .SET_CODE   (SET_CODE),
    .GUESS_L1   (GUESS_L1),
    .GUESS_L2   (GUESS_L2)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .levelIn    (levelIn),
    .readData   (readData),
    .cfgTarget1 (cfgTarget1),
    .cfgMargin1 (cfgMargin1),
    .cfgTarget2 (cfgTarget2),
    .cfgMargin2 (cfgMargin2),
    .cfgMaxIter (cfgMaxIter),
    .pulseCode  (pulseCode),
    .iterCount  (iterCount),
    .fail       (fail),
    .endLevel   (endLevel),
    .inWindow   (inWindow),
    .iterLimit  (iterLimit)
  );

endmodule

// File: tb/test_mlcWriteVerify.sv
`timescale 1ns/1ps
module test_mlcWriteVerify;

  localparam int GS = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] levelIn = 2'd0;
  logic [7:0] cfgTarget1 = 8'd66, cfgMargin1 = 8'd5;
  logic [7:0] cfgTarget2 = 8'd102, cfgMargin2 = 8'd5;
  logic [4:0] cfgMaxIter = 5'd16;
  logic       pulseReq, readReq, done, fail;
  logic [7:0] pulseCode;
  logic [4:0] iterCount;
  logic       pulseAck = 1'b0, readValid = 1'b0;
  logic [7:0] readData = 8'd0;

  always #2 clk = ~clk;

  mlcWriteVerify i_mlcWriteVerify (
    .clk(clk), .rstN(rstN), .start(start), .levelIn(levelIn),
    .cfgTarget1(cfgTarget1), .cfgMargin1(cfgMargin1),
    .cfgTarget2(cfgTarget2), .cfgMargin2(cfgMargin2),
    .cfgMaxIter(cfgMaxIter), .pulseReq(pulseReq), .pulseCode(pulseCode),
    .pulseAck(pulseAck), .readReq(readReq), .readValid(readValid),
    .readData(readData), .done(done), .fail(fail), .iterCount(iterCount)
  );

  int checks = 0, errors = 0;
  int expCodeQ[$];
  int expFailQ[$];
  int expIterQ[$];
  string curTag = "R1";
  int readCnt = 0, doneCnt = 0, expReads = 0, lastIters = 0;
  int cellStuck = 0, stuckVal = 0, cellOff = 0;
  int pulseLat = 0, readLat = 0;
  int lastCode = 0;
  bit finished = 0;

  function automatic int cellRead(int code);
    int v;
    if (cellStuck != 0) return stuckVal;
    v = cellOff - code;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  // expected behaviour taken from the requirements
  task automatic buildExpect(input int level);
    int code, iters, tgt, mg, e, s, rd, lim;
    bit outer;
    outer = (level == 0) || (level == 3);
    case (level)
      0: code = 255;
      1: code = 150;
      2: code = 110;
      default: code = 32;
    endcase
    tgt = (level == 2) ? int'(cfgTarget2) : int'(cfgTarget1);
    mg  = (level == 2) ? int'(cfgMargin2) : int'(cfgMargin1);
    lim = (cfgMaxIter == 0) ? 1 : int'(cfgMaxIter);
    iters = 0;
    expReads = 0;
    forever begin
      expCodeQ.push_back(code);
      iters++;
      if (outer) begin
        expFailQ.push_back(0);
        break;
      end
      expReads++;
      rd = cellRead(code);
      e = rd - tgt;
      if (e <= mg && e >= -mg) begin
        expFailQ.push_back(0);
        break;
      end
      if (iters >= lim) begin
        expFailQ.push_back(1);
        break;
      end
      s = e >>> GS;
      if (s == 0) s = (e > 0) ? 1 : -1;
      code = code + s;
      if (code < 0) code = 0;
      if (code > 255) code = 255;
    end
    expIterQ.push_back(iters);
    lastIters = iters;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // analog-side responder
  int pCnt = 0, rCnt = 0;
  always @(negedge clk) begin
    pulseAck  = 1'b0;
    readValid = 1'b0;
    if (pulseReq) begin
      if (pCnt >= pulseLat) begin
        pulseAck = 1'b1;
        lastCode = int'(pulseCode);
        pCnt = 0;
      end else pCnt++;
    end
    if (readReq) begin
      if (rCnt >= readLat) begin
        readValid = 1'b1;
        readData  = 8'(cellRead(lastCode));
        rCnt = 0;
      end else rCnt++;
    end
  end

  // monitor: pops the scoreboard as results appear
  logic prevReq = 1'b0, prevRd = 1'b0;
  logic [7:0] prevCode = 8'd0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pulseReq && !prevReq) begin
        if (expCodeQ.size() == 0) check(0, curTag, "unexpected pulse code", int'(pulseCode), -1);
        else begin
          int e;
          e = expCodeQ.pop_front();
          check(int'(pulseCode) == e, curTag, "pulse code", int'(pulseCode), e);
        end
      end
      if (pulseReq && prevReq)
        check(pulseCode == prevCode, "R9", "pulse code held", int'(pulseCode), int'(prevCode));
      if (readReq && !prevRd) readCnt++;
      if (done) begin
        doneCnt++;
        if (expFailQ.size() == 0) check(0, "R11", "unexpected done", 1, 0);
        else begin
          int ef, ei;
          ef = expFailQ.pop_front();
          ei = expIterQ.pop_front();
          check(int'(fail) == ef, curTag, "fail flag", int'(fail), ef);
          check(int'(iterCount) == ei, curTag, "iteration count", int'(iterCount), ei);
        end
      end
    end
    prevReq  = pulseReq;
    prevRd   = readReq;
    prevCode = pulseCode;
  end

  task automatic runOp(input int level, input string tag, input bit extraStart);
    curTag = tag;
    @(negedge clk);
    buildExpect(level);
    readCnt = 0;
    doneCnt = 0;
    levelIn = 2'(level);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extraStart) begin
      repeat (3) @(negedge clk);
      levelIn = 2'(3 - level);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      levelIn = 2'(level);
    end
    while (doneCnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(doneCnt == 1, extraStart ? "R10" : "R11", "done count", doneCnt, 1);
    check(readCnt == expReads, (level == 0 || level == 3) ? "R2" : "R4", "read count", readCnt, expReads);
    check(expCodeQ.size() == 0, tag, "missing pulses", expCodeQ.size(), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL %s watchdog expired: actual hung expected done", curTag);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 0 && fail == 0, "R1", "done/fail after reset", {done, fail}, 0);
    check(pulseReq == 0 && readReq == 0, "R1", "requests after reset", {pulseReq, readReq}, 0);
    check(iterCount == 0, "R1", "iterCount after reset", int'(iterCount), 0);

    // R2 outer levels
    runOp(0, "R2", 0);
    pulseLat = 2;
    runOp(3, "R2", 0);

    // R3 / R4 single-hit middle levels
    pulseLat = 0; readLat = 0;
    cellOff = 220;
    runOp(1, "R3", 0);
    cellOff = 210;
    runOp(2, "R3", 0);

    // R5 multi-step corrections upward and downward
    pulseLat = 1; readLat = 2;
    cellOff = 260;
    runOp(1, "R5", 0);
    check(lastIters > 1, "R5", "needs several steps", lastIters, 2);
    cellOff = 150;
    runOp(2, "R5", 0);

    // R8 window hit exactly at the budget
    cellOff = 260;
    runOp(1, "R8", 0);
    cfgMaxIter = 5'(lastIters);
    runOp(1, "R8", 0);
    cfgMaxIter = 5'd16;

    // R6 minimum step with zero margin, R8 limit
    cfgMargin1 = 8'd0;
    cellStuck = 1; stuckVal = 67;
    cfgMaxIter = 5'd4;
    runOp(1, "R6", 0);
    cfgMargin1 = 8'd5;
    // R11 hold after done
    repeat (5) @(negedge clk);
    check(done == 0, "R11", "done low after strobe", int'(done), 0);
    check(fail == 1, "R11", "fail held", int'(fail), 1);
    check(iterCount == 4, "R11", "iterCount held", int'(iterCount), 4);

    // R7 saturation high and low
    cfgMaxIter = 5'd16;
    stuckVal = 255;
    runOp(1, "R7", 0);
    stuckVal = 0;
    pulseLat = 0; readLat = 0;
    runOp(2, "R7", 0);

    // R8 zero budget acts as one
    cfgMaxIter = 5'd0;
    stuckVal = 200;
    runOp(2, "R8", 0);

    // R10 start ignored while busy
    cfgMaxIter = 5'd16;
    cellStuck = 0; cellOff = 260;
    pulseLat = 3; readLat = 3;
    runOp(1, "R10", 1);
    runOp(0, "R10", 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule